// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a single-port synchronous SRAM with registered inputs and a registered read-data path. A word is a set of byte lanes (four by default). Each access starts on a rising clock edge from one of two address strobes. One strobe is meant for a processor and the other for a cache controller. Three synchronous selects gate each access. A global write, a byte-write enable and per-lane write selects decide whether the access writes and which lanes it writes.

Read data passes through an output register and reaches the data bus one edge after the read is accepted. An asynchronous, active-low output enable gates the drive. The output-drive state follows two rules. Outputs stay off during the first cycle after the device leaves the deselected state. After a deselect they keep driving for one more cycle and then turn off. A two-bit burst counter provides the low address bits for follow-on cycles, in linear or interleaved order. The data bus is split into an input, an output and a drive-enable, so a pad ring or bench can model the tri-state.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset is released, `dataOutEn` is low until a read has been accepted.
- R2: A read starts at an edge when at least one valid strobe is low, all three selects are active (`sel1N`=0, `sel2`=1, `sel3N`=0), and the strobe is `procStrobeN`, or `globalWrN` and `byteWrEnN` are both high. The word at the captured address is on `dataOut` with `dataOutEn` high after the following edge, while `outEnN` is low.
- R3: `procStrobeN` has no effect while `sel1N` is high. The strobe then neither starts an access nor deselects the device, and a selected device goes on as in a cycle with no strobe.
- R4: When an access starts while the device is deselected, `dataOutEn` stays low between the start edge and the next edge, whatever `outEnN` is.
- R5: A strobe edge with any select inactive deselects the device. The drive state set by earlier reads holds for the cycle after that edge, and `dataOutEn` is low after the next edge.
- R6: `dataOutEn` follows `outEnN` with no clock: it is low whenever `outEnN` is high.
- R7: An access started by `ctrlStrobeN` with `globalWrN` low writes all four lanes of `dataIn`, whatever `byteWrEnN` and `laneSelN` are.
- R8: With `globalWrN` high and `byteWrEnN` low, only the lanes whose `laneSelN` bit is low are written. Bit i covers `dataIn[8i+7:8i]`, and the other lanes keep their contents.
- R9: An access started by `procStrobeN` ignores the write controls and reads. In a later cycle with both strobes high, the write controls write at the burst address.
- R10: In a selected cycle with both strobes high, `advanceN` low first steps the two low address bits. With `orderSel`=0 the k-th step gives (start+k) mod 4, and with `orderSel`=1 it gives start XOR k. `advanceN` high holds the address, and such a cycle without a write reads it again.
- R11: A new read can be accepted at every edge, and each one's data appears after the edge that follows it.
- R12: After a write edge that is not directly preceded by an accepted read, `dataOutEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, captured when an access starts |
| procStrobeN | input | 1 | Processor address strobe, active low, gated by `sel1N` |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| sel1N | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3N | input | 1 | Chip select 3, active low |
| globalWrN | input | 1 | Global write of all lanes, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneSelN | input | 4 | Per-lane write selects, active low |
| orderSel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dataIn | input | 32 | Write data |
| dataOut | output | 32 | Registered read data |
| dataOutEn | output | 1 | Drive enable for `dataOut` |

## Verification
A read accepted at edge e has its first-cycle window after edge e, when the drive must be off if the device was deselected. Its data is due after edge e+1. A deselect at edge d leaves the drive as it was after d and removes it after d+1. An output-enable change shows at once. The driver records each expectation against the number of the edge after which it is due. The monitor samples one nanosecond after every rising edge and compares the entries whose edge number matches. An entry still in the queue after its edge has passed counts as a failure. The output-enable check is made between edges, right after the pin changes.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  parameter int unsigned LANES   = 4;
  parameter int unsigned BYTE_W  = 8;
  parameter int unsigned BURST_W = 2;
  localparam int unsigned DATA_W = LANES * BYTE_W;

  // Per-edge commands from the control to the datapath.
  typedef struct packed {
    logic             loadAddr;  // capture a fresh address
    logic             advance;   // step the burst counter this edge
    logic             readNow;   // a read is accepted this edge
    logic             loadOut;   // load the output register this edge
    logic [LANES-1:0] wrLanes;   // lanes written this edge
  } strobe_t;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             procStrobeN,
  input  logic             ctrlStrobeN,
  input  logic             advanceN,
  input  logic             sel1N,
  input  logic             sel2,
  input  logic             sel3N,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] laneSelN,
  output strobe_t          stb,
  output logic             selQ,
  output logic             driveQ
);
  logic selAll, procHit, ctrlHit, strobeEv;
  logic startOk, deselEv, contCyc, wantWr, doWrite;
  logic rdQ;
  logic [LANES-1:0] laneMask;

  always_comb begin
    selAll   = !sel1N && sel2 && !sel3N;
    procHit  = !procStrobeN && !sel1N;            // processor strobe gated by select 1
    ctrlHit  = !ctrlStrobeN && !procHit;          // processor strobe wins when both valid
    strobeEv = procHit || ctrlHit;
    startOk  = strobeEv && selAll;
    deselEv  = strobeEv && !selAll;
    contCyc  = !strobeEv && selQ;
    wantWr   = !globalWrN || !byteWrEnN;
    if (!globalWrN)      laneMask = '1;
    else if (!byteWrEnN) laneMask = ~laneSelN;
    else                 laneMask = '0;
    doWrite  = (ctrlHit && selAll && wantWr) || (contCyc && wantWr);

    stb.loadAddr = startOk;
    stb.advance  = contCyc && !advanceN;
    stb.readNow  = (startOk && (procHit || !wantWr)) || (contCyc && !wantWr);
    stb.loadOut  = rdQ;
    stb.wrLanes  = doWrite ? laneMask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= 1'b0;
      rdQ    <= 1'b0;
      driveQ <= 1'b0;
    end else begin
      if (startOk)      selQ <= 1'b1;
      else if (deselEv) selQ <= 1'b0;
      rdQ <= stb.readNow;
      // Drive turns on one edge after an accepted read. It holds while the
      // device was selected at this edge and nothing is written. Because the
      // old selection is used, a deselect keeps the drive one more cycle.
      driveQ <= rdQ || (selQ && driveQ && !doWrite);
    end
  end
endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadAddr,
  input  logic              advance,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] curAddr
);
  logic [ADDR_W-1:BURST_W] hiQ;
  logic [BURST_W-1:0]      startQ, cntQ, cntEff, lowSeq;

  always_comb begin
    cntEff  = advance ? cntQ + BURST_W'(1) : cntQ;
    lowSeq  = orderSel ? (startQ ^ cntEff) : (startQ + cntEff);
    curAddr = loadAddr ? addrIn : {hiQ, lowSeq};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ    <= '0;
      startQ <= '0;
      cntQ   <= '0;
    end else if (loadAddr) begin
      hiQ    <= addrIn[ADDR_W-1:BURST_W];
      startQ <= addrIn[BURST_W-1:0];
      cntQ   <= '0;
    end else if (advance) begin
      cntQ <= cntEff;
    end
  end
endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] curAddr, rdAddrQ;

  sbs_burst #(.ADDR_W(ADDR_W)) uBurst (
    .clk      (clk),
    .rstN     (rstN),
    .loadAddr (stb.loadAddr),
    .advance  (stb.advance),
    .orderSel (orderSel),
    .addrIn   (addrIn),
    .curAddr  (curAddr)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdAddrQ <= '0;
    else if (stb.readNow) rdAddrQ <= curAddr;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BYTE_W-1:0] cells [DEPTH];
    logic [BYTE_W-1:0] outByte;

    always_ff @(posedge clk) begin
      if (stb.wrLanes[g]) cells[curAddr] <= dataIn[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            outByte <= '0;
      else if (stb.loadOut) outByte <= cells[rdAddrQ];
    end

    assign dataOut[g*BYTE_W +: BYTE_W] = outByte;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              sel1N,
  input  logic              sel2,
  input  logic              sel3N,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneSelN,
  input  logic              orderSel,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  strobe_t stb;
  logic    selQ, driveQ;

  sbs_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .sel1N       (sel1N),
    .sel2        (sel2),
    .sel3N       (sel3N),
    .globalWrN   (globalWrN),
    .byteWrEnN   (byteWrEnN),
    .laneSelN    (laneSelN),
    .stb         (stb),
    .selQ        (selQ),
    .driveQ      (driveQ)
  );

  sbs_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .orderSel (orderSel),
    .addrIn   (addr),
    .dataIn   (dataIn),
    .dataOut  (dataOut)
  );

  // Output enable acts without a clock on the registered drive state.
  assign dataOutEn = driveQ && !outEnN;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk (
  input logic clk,
  input logic rstN,
  input logic procStrobeN,
  input logic ctrlStrobeN,
  input logic sel1N,
  input logic sel2,
  input logic sel3N,
  input logic globalWrN,
  input logic byteWrEnN,
  input logic outEnN,
  input logic dataOutEn,
  input logic selQ,
  input logic driveQ
);
  logic allSel, procLive, anyStrobe;
  assign allSel    = !sel1N && sel2 && !sel3N;
  assign procLive  = !procStrobeN && !sel1N;
  assign anyStrobe = procLive || !ctrlStrobeN;

  // R1: quiet bus right after reset release
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !dataOutEn);

  // R2: an accepted read drives two edges later
  p_read_drives_r2: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrobe && allSel && (procLive || (globalWrN && byteWrEnN))) |=> ##1 driveQ);

  // R3: a gated processor strobe leaves the selection alone
  p_proc_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && sel1N && ctrlStrobeN) |=> $stable(selQ));

  // R4: first cycle after leaving deselect is undriven
  p_first_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!selQ && anyStrobe && allSel) |=> !driveQ);

  // R5: drive holds across the deselect edge
  p_dcd_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (selQ && anyStrobe && !allSel && driveQ) |=> driveQ);

  // R5: drive is gone one edge after the deselect
  p_dcd_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrobe && !allSel) |=> ##1 !driveQ);

  // R6: output enable gates the drive
  p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataOutEn);
endmodule

bind sync_burst_sram sync_burst_sram_chk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .procStrobeN (procStrobeN),
  .ctrlStrobeN (ctrlStrobeN),
  .sel1N       (sel1N),
  .sel2        (sel2),
  .sel3N       (sel3N),
  .globalWrN   (globalWrN),
  .byteWrEnN   (byteWrEnN),
  .outEnN      (outEnN),
  .dataOutEn   (dataOutEn),
  .selQ        (selQ),
  .driveQ      (driveQ)
);

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/100ps
module test_sync_burst_sram;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic          rstN;
  logic [AW-1:0] addr;
  logic          procStrobeN, ctrlStrobeN, advanceN;
  logic          sel1N, sel2, sel3N;
  logic          globalWrN, byteWrEnN;
  logic [3:0]    laneSelN;
  logic          orderSel, outEnN;
  logic [31:0]   dataIn, dataOut;
  logic          dataOutEn;

  sync_burst_sram #(.ADDR_W(AW)) i_sync_burst_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .sel1N(sel1N), .sel2(sel2),
    .sel3N(sel3N), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneSelN(laneSelN), .orderSel(orderSel), .outEnN(outEnN),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    logic        en;
    logic [31:0] d;
    logic        chkD;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  exp_t        curIt;
  int          nChk = 0, nFail = 0;
  int          edgeNo = 0;
  bit          done = 0;
  logic [31:0] refMem [64];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectAt(input int at, input logic en, input logic [31:0] d, input logic chkD, input string tag);
    exp_t it;
    it.at = at; it.en = en; it.d = d; it.chkD = chkD; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: 1 ns after each rising edge, compare the items due for that edge.
  always begin
    @(posedge clk);
    #1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      curIt = sb.pop_front();
      if (curIt.at < cyc)
        check(1'b0, {curIt.tag, " missed"}, 32'(cyc), 32'(curIt.at));
      else begin
        check(dataOutEn === curIt.en, {curIt.tag, " enable"}, 32'(dataOutEn), 32'(curIt.en));
        if (curIt.en && curIt.chkD)
          check(dataOut === curIt.d, {curIt.tag, " data"}, dataOut, curIt.d);
      end
    end
  end

  // One cycle of pin values, applied at the falling edge; edgeNo is the sampling edge.
  task automatic op(input logic pS, input logic cS, input logic adv, input logic s1N, input logic s2,
                    input logic s3N, input logic gwN, input logic bweN, input logic [3:0] lsN,
                    input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    procStrobeN = pS; ctrlStrobeN = cS; advanceN = adv;
    sel1N = s1N; sel2 = s2; sel3N = s3N;
    globalWrN = gwN; byteWrEnN = bweN; laneSelN = lsN;
    addr = a; dataIn = d;
    edgeNo = cyc + 1;
  endtask

  task automatic refApply(input logic [AW-1:0] a, input logic [31:0] d, input logic gwN,
                          input logic bweN, input logic [3:0] lsN);
    for (int l = 0; l < 4; l++)
      if (!gwN || (!bweN && !lsN[l])) refMem[a][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic pushRead(input logic [AW-1:0] a, input string tag);
    expectAt(edgeNo + 1, 1'b1, refMem[a], 1'b1, tag);
  endtask

  task automatic idle();        op(1,1,1,0,1,0,1,1,4'hF,'0,'0); endtask
  task automatic desel();       op(1,0,1,0,0,0,1,1,4'hF,'0,'0); endtask
  task automatic rdC(input logic [AW-1:0] a, input string tag);
    op(1,0,1,0,1,0,1,1,4'hF,a,'0); pushRead(a, tag);
  endtask
  task automatic advRead(input logic [AW-1:0] a, input string tag);
    op(1,1,0,0,1,0,1,1,4'hF,'0,'0); pushRead(a, tag);
  endtask
  task automatic wrC(input logic [AW-1:0] a, input logic [31:0] d, input logic gwN,
                     input logic bweN, input logic [3:0] lsN);
    op(1,0,1,0,1,0,gwN,bweN,lsN,a,d); refApply(a, d, gwN, bweN, lsN);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    check(1'b0, "watchdog", 32'(cyc), 32'h0);
    summary();
  end

  initial begin
    rstN = 1'b0; outEnN = 1'b0; orderSel = 1'b0;
    procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1; sel1N = 0; sel2 = 1; sel3N = 0;
    globalWrN = 1; byteWrEnN = 1; laneSelN = 4'hF; addr = '0; dataIn = '0;
    for (int i = 0; i < 64; i++) refMem[i] = 'x;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectAt(cyc + 1, 1'b0, '0, 1'b0, "R1 after reset");

    // Preload with global writes.
    for (int i = 0; i < 16; i++)
      wrC(AW'(i), {8'(i), 8'(i*3+1), 8'(i*7+2), 8'(i*13+5)}, 1'b0, 1'b1, 4'hF);

    desel();
    idle();

    // R4 then R2: processor-strobe read out of the deselected state.
    op(0,1,1,0,1,0,1,1,4'hF,6'd3,'0);
    expectAt(edgeNo, 1'b0, '0, 1'b0, "R4 first cycle off");
    pushRead(6'd3, "R2 single read");

    // R11: reads on consecutive edges.
    rdC(6'd1, "R11 b2b 1");
    rdC(6'd2, "R11 b2b 2");
    rdC(6'd5, "R11 b2b 3");
    idle(); pushRead(6'd5, "R10 held read");

    // R5: deselect keeps drive one cycle, then off.
    desel();
    expectAt(edgeNo, 1'b1, refMem[5], 1'b1, "R5 drive at deselect edge");
    expectAt(edgeNo + 1, 1'b0, '0, 1'b0, "R5 off after next edge");

    // R3 while deselected: gated processor strobe starts nothing.
    op(0,1,1,1,1,0,1,1,4'hF,6'd9,'0);
    expectAt(edgeNo, 1'b0, '0, 1'b0, "R3 gated strobe deselected");
    expectAt(edgeNo + 1, 1'b0, '0, 1'b0, "R3 gated strobe deselected next");

    // R3 while selected: gated strobe with another select inactive must not deselect.
    rdC(6'd2, "R3 setup read");
    op(0,1,1,1,0,0,1,1,4'hF,6'd9,'0); pushRead(6'd2, "R3 gated strobe continues");
    idle(); pushRead(6'd2, "R3 still selected");

    // R6: output enable acts between edges.
    @(negedge clk);
    outEnN = 1'b1; #0.5;
    check(dataOutEn === 1'b0, "R6 disable async", 32'(dataOutEn), 32'h0);
    outEnN = 1'b0; #0.5;
    check(dataOutEn === 1'b1, "R6 enable async", 32'(dataOutEn), 32'h1);

    // R9: processor-strobe start with global write low still reads.
    op(0,1,1,0,1,0,0,1,4'hF,6'd10,32'hDEAD_BEEF); pushRead(6'd10, "R9 write ignored");
    // R9 / R8: byte write in the following cycle at the held address (lanes 0 and 2).
    op(1,1,1,0,1,0,1,0,4'b1010,'0,32'hA1B2_C3D4); refApply(6'd10, 32'hA1B2_C3D4, 1'b1, 1'b0, 4'b1010);
    // R10 / R12: advance to address 11 and write lanes 0 and 3; no read before this edge.
    op(1,1,0,0,1,0,1,0,4'b0110,'0,32'h5566_7788); refApply(6'd11, 32'h5566_7788, 1'b1, 1'b0, 4'b0110);
    expectAt(edgeNo, 1'b0, '0, 1'b0, "R12 off after write");
    idle(); pushRead(6'd11, "R8 lanes at advanced address");
    rdC(6'd10, "R8 merged lanes");

    // R7: global write overrides lane selects.
    wrC(6'd12, 32'h1357_9BDF, 1'b0, 1'b0, 4'b0111);
    rdC(6'd12, "R7 global write all lanes");

    // R10: linear burst from low bits 1.
    rdC(6'd5, "R10 linear start");
    advRead(6'd6, "R10 linear k1");
    advRead(6'd7, "R10 linear k2");
    advRead(6'd4, "R10 linear k3");

    desel();
    idle();
    orderSel = 1'b1;
    rdC(6'd5, "R10 interleaved start");
    advRead(6'd4, "R10 interleaved k1");
    advRead(6'd7, "R10 interleaved k2");
    advRead(6'd6, "R10 interleaved k3");

    desel();
    repeat (4) idle();
    if (sb.size() != 0) check(1'b0, "queue drained", 32'(sb.size()), 32'h0);
    summary();
  end
endmodule